// File: doc/BRIEF.md
# Low-Power Mode and Clock-Divide Controller

This block chooses the operating power state of a processor core and produces the divided core clock from the input clock. Configuration arrives as plain register bits: a two-bit mode code, an expiry-enable bit, two three-bit divide exponents (one for the fast sub-mode, one for the slow sub-mode) and a speed-select level. A one-cycle request strobe moves the block from normal operation into the selected low-power state. A wake event, or a timer expiry with expiry signalling enabled, brings it back to normal operation at full speed.

While the block is in normal or doze state the core clock runs. In sleep, deep-sleep and power-down it is parked low. A new divide ratio is only adopted when the core clock falls, so no phase is ever cut short. When expiry signalling is enabled, a timer expiry drives the expiry-wake output at once, without waiting for any clock edge, so that an external supply switch can be closed. The output stays high until the block is back in normal state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When `lp_req` is sampled high in normal state, `mode_sel` picks the next state: 2'b00 stays normal, 2'b01 enters doze, 2'b10 enters sleep, and 2'b11 enters deep-sleep if `texp_en` is 1 or power-down if it is 0. The change is visible after the sampling edge.
- R2: During and after reset the state is normal, the fast sub-mode is selected, `mode_stat` is 5'b00001 and `core_clk` is low.
- R3: In the fast sub-mode the period of `core_clk` is 2^`div_hi` input-clock cycles. A `div_hi` of 0 gives the minimum period of 2.
- R4: In the slow sub-mode the period of `core_clk` is 2^(`div_lo`+1) input-clock cycles.
- R5: A new divide ratio is adopted only at a falling edge of `core_clk`. A high phase already in progress keeps the old half-period, and the low phase that follows uses the new one.
- R6: The slow sub-mode is selected when `spd_low` is sampled going from 0 to 1. It is left when `spd_low` is sampled at 0.
- R7: `core_clk` keeps running in normal and doze states. In sleep, deep-sleep and power-down it stops and stays low.
- R8: While the block is in a low-power state, `lp_req` has no effect.
- R9: In any low-power state, `wake_evt`, or `tmr_exp` with `texp_en` set, returns the block to normal state at the next edge and forces the fast sub-mode, whatever level `spd_low` holds.
- R10: `exp_wake` goes high combinationally whenever `tmr_exp` and `texp_en` are both 1. With `texp_en` at 0, `tmr_exp` neither raises `exp_wake` nor wakes the block.
- R11: Once raised, `exp_wake` stays high until the state is normal, and falls at the first input-clock edge after that which sees no enabled expiry.
- R12: `mode_stat` is one-hot: bit 0 normal, bit 1 doze, bit 2 sleep, bit 3 deep-sleep, bit 4 power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Low-power state code |
| texp_en | input | 1 | Expiry signalling enable; also selects deep-sleep over power-down |
| div_hi | input | 3 | Divide exponent for the fast sub-mode |
| div_lo | input | 3 | Divide exponent for the slow sub-mode (plus one) |
| spd_low | input | 1 | Speed-select level; a rising transition selects the slow sub-mode |
| lp_req | input | 1 | Strobe to enter the state chosen by `mode_sel` |
| wake_evt | input | 1 | Wake event |
| tmr_exp | input | 1 | Timer expiry |
| core_clk | output | 1 | Divided core clock |
| mode_stat | output | 5 | One-hot state status |
| exp_wake | output | 1 | Expiry-wake request for external power restoration |

## Verification
State changes from `lp_req` and `wake_evt` register on one input-clock edge. The bench therefore drives stimulus at a falling edge of the input clock and reads `mode_stat` at the next falling edge. `exp_wake` has a combinational path, so the bench checks it one nanosecond after driving `tmr_exp`, before any rising edge. The bench then checks its hold one falling edge later and its clear one falling edge after that.

Divider ratios only settle at a `core_clk` fall. For that reason the driver waits three `core_clk` rises after any change before it queues an expected period, and the monitor measures from the next rise to the one after it. The boundary rule is timed directly: the bench measures the high phase in which a ratio write lands, and then the low phase that follows it.

// File: rtl/pmc_pkg.sv
// Shared types for the power-mode controller.
// Assumes the enum order matches the one-hot status bit order.
package pmc_pkg;

    localparam int NSTATES = 5;

    typedef enum logic [2:0] {
        PM_NORM   = 3'd0,
        PM_DOZE   = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_DSLEEP = 3'd3,
        PM_PDOWN  = 3'd4
    } pm_state_e;

endpackage

// File: rtl/pmc_mode_fsm.sv
// Power-state sequencer and speed sub-mode register.
// Assumes lp_req is a single-cycle strobe and all inputs are synchronous to clk.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       texp_en,
    input  logic       lp_req,
    input  logic       wake_evt,
    input  logic       tmr_exp,
    input  logic       spd_low,
    output pm_state_e  state,
    output logic       low_sel,
    output logic       run
);

    pm_state_e state_q, state_d;
    logic      low_q, low_d;
    logic      spd_prev_q;
    logic      in_lowpwr;
    logic      wake_hit;

    assign in_lowpwr = (state_q != PM_NORM);
    assign wake_hit  = in_lowpwr && (wake_evt || (tmr_exp && texp_en));

    // Next-state selection: entry only from normal, exit only on a wake.
    always_comb begin
        state_d = state_q;
        if (state_q == PM_NORM) begin
            if (lp_req) begin
                unique case (mode_sel)
                    2'b01:   state_d = PM_DOZE;
                    2'b10:   state_d = PM_SLEEP;
                    2'b11:   state_d = texp_en ? PM_DSLEEP : PM_PDOWN;
                    default: state_d = PM_NORM;
                endcase
            end
        end else if (wake_hit) begin
            state_d = PM_NORM;
        end
    end

    // Sub-mode update: a wake forces fast, a 0->1 on spd_low selects slow.
    always_comb begin
        low_d = low_q;
        if (wake_hit)
            low_d = 1'b0;
        else if (!spd_low)
            low_d = 1'b0;
        else if (!spd_prev_q)
            low_d = 1'b1;
    end

    // State, sub-mode and speed-select history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PM_NORM;
            low_q      <= 1'b0;
            spd_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            low_q      <= low_d;
            spd_prev_q <= spd_low;
        end
    end

    assign state   = state_q;
    assign low_sel = low_q;
    assign run     = (state_q == PM_NORM) || (state_q == PM_DOZE);

endmodule

// File: rtl/pmc_clk_div.sv
// Power-of-two clock divider with boundary-only ratio changes and a parked stop.
// Assumes exponents are static for a few cycles; exponent 0 is raised to 1.
module pmc_clk_div #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            low_sel,
    input  logic [DIVW-1:0] div_hi,
    input  logic [DIVW-1:0] div_lo,
    output logic            clk_out
);

    localparam int EXPW = DIVW + 1;
    localparam int MAXE = 2 ** DIVW;
    localparam int CNTW = MAXE;

    logic [EXPW-1:0] exp_req;
    logic [EXPW-1:0] exp_eff;
    logic [CNTW-1:0] half_new;
    logic [CNTW-1:0] half_q;
    logic [CNTW-1:0] cnt_q;
    logic            clk_q;
    logic            stop_q;
    logic            at_edge;

    // Requested exponent from the active sub-mode, clamped to at least 1.
    always_comb begin
        exp_req  = low_sel ? ({1'b0, div_lo} + EXPW'(1)) : {1'b0, div_hi};
        exp_eff  = (exp_req == '0) ? EXPW'(1) : exp_req;
        half_new = CNTW'(1) << (exp_eff - EXPW'(1));
    end

    assign at_edge = (cnt_q == half_q - CNTW'(1));

    // Phase counter: toggles the output every half period, latches the new half-period on a fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            cnt_q  <= '0;
            half_q <= CNTW'(1);
            stop_q <= 1'b1;
        end else if (stop_q) begin
            if (run) begin
                stop_q <= 1'b0;
                half_q <= half_new;
                cnt_q  <= '0;
            end
        end else if (at_edge) begin
            cnt_q <= '0;
            if (!run) begin
                stop_q <= 1'b1;
                clk_q  <= 1'b0;
            end else begin
                clk_q <= ~clk_q;
                if (clk_q)
                    half_q <= half_new;
            end
        end else begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end

    assign clk_out = clk_q;

endmodule

// File: rtl/pmc_exp_flag.sv
// Expiry-wake request: immediate combinational raise, held until normal state.
// Assumes in_norm comes from the registered state.
module pmc_exp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_exp,
    input  logic texp_en,
    input  logic in_norm,
    output logic exp_wake
);

    logic hold_q;
    logic fire;

    assign fire = tmr_exp && texp_en;

    // Hold register: set by an enabled expiry, cleared once in normal state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (fire)
            hold_q <= 1'b1;
        else if (in_norm)
            hold_q <= 1'b0;
    end

    assign exp_wake = fire || hold_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top level of the power-mode and clock-divide controller.
// Assumes a single input clock and synchronous active-low reset.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DIVW = 3
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            texp_en,
    input  logic [DIVW-1:0] div_hi,
    input  logic [DIVW-1:0] div_lo,
    input  logic            spd_low,
    input  logic            lp_req,
    input  logic            wake_evt,
    input  logic            tmr_exp,
    output logic            core_clk,
    output logic [NSTATES-1:0] mode_stat,
    output logic            exp_wake
);

    pm_state_e state;
    logic      low_sel;
    logic      run;

    pmc_mode_fsm u_fsm (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .texp_en  (texp_en),
        .lp_req   (lp_req),
        .wake_evt (wake_evt),
        .tmr_exp  (tmr_exp),
        .spd_low  (spd_low),
        .state    (state),
        .low_sel  (low_sel),
        .run      (run)
    );

    pmc_clk_div #(.DIVW(DIVW)) u_div (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .run     (run),
        .low_sel (low_sel),
        .div_hi  (div_hi),
        .div_lo  (div_lo),
        .clk_out (core_clk)
    );

    pmc_exp_flag u_exp (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .tmr_exp  (tmr_exp),
        .texp_en  (texp_en),
        .in_norm  (state == PM_NORM),
        .exp_wake (exp_wake)
    );

    // One-hot status decode, one bit per state.
    for (genvar gi = 0; gi < NSTATES; gi++) begin : g_stat
        assign mode_stat[gi] = (state == pm_state_e'(gi));
    end

endmodule

// File: rtl/pmc_checks.sv
// Property checker for the power-mode controller, bound to the top level.
// Assumes the status bit order: normal, doze, sleep, deep-sleep, power-down.
module pmc_checks (
    input logic       clk_in,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       texp_en,
    input logic       lp_req,
    input logic       wake_evt,
    input logic       tmr_exp,
    input logic       core_clk,
    input logic [4:0] mode_stat,
    input logic       exp_wake
);

    // R12: exactly one status bit set.
    a_r12_onehot: assert property (@(posedge clk_in) disable iff (!rst_n)
        $countones(mode_stat) == 1);

    // R1: a strobe with code 01 in normal state enters doze.
    a_r1_doze_entry: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_stat[0] && lp_req && mode_sel == 2'b01) |=> mode_stat[1]);

    // R9: a wake event in a low-power state returns to normal.
    a_r9_wake_norm: assert property (@(posedge clk_in) disable iff (!rst_n)
        (|mode_stat[4:1] && wake_evt) |=> (mode_stat == 5'b00001));

    // R8: with no wake, a low-power state holds whatever lp_req does.
    a_r8_lp_ignored: assert property (@(posedge clk_in) disable iff (!rst_n)
        (|mode_stat[4:1] && !wake_evt && !(tmr_exp && texp_en)) |=> $stable(mode_stat));

    // R7: a parked clock stays low in the stop states.
    a_r7_parked: assert property (@(posedge clk_in) disable iff (!rst_n)
        (|mode_stat[4:2] && !core_clk) |=> !core_clk);

    // R10: an enabled expiry raises exp_wake at once.
    a_r10_exp_raise: assert property (@(posedge clk_in) disable iff (!rst_n)
        (tmr_exp && texp_en) |-> exp_wake);

    // R11: in normal state with no expiry, exp_wake is low one edge later.
    a_r11_exp_clear: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_stat[0] && !(tmr_exp && texp_en)) |=> (!exp_wake || (tmr_exp && texp_en)));

endmodule

bind pwr_mode_ctrl pmc_checks u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .texp_en   (texp_en),
    .lp_req    (lp_req),
    .wake_evt  (wake_evt),
    .tmr_exp   (tmr_exp),
    .core_clk  (core_clk),
    .mode_stat (mode_stat),
    .exp_wake  (exp_wake)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected core-clock periods and the monitor measures them.
module sim_pwr_mode_ctrl;

    logic       clk_in = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       texp_en = 1'b0;
    logic [2:0] div_hi = 3'd2;
    logic [2:0] div_lo = 3'd1;
    logic       spd_low = 1'b0;
    logic       lp_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       tmr_exp = 1'b0;
    logic       core_clk;
    logic [4:0] mode_stat;
    logic       exp_wake;

    int    n_chk = 0;
    int    n_fail = 0;
    int    rise_cnt = 0;
    bit    done = 1'b0;
    int    per_q[$];
    string tag_q[$];
    bit    have_ref = 1'b0;
    time   ref_t = 0;

    always #10 clk_in = ~clk_in;

    pwr_mode_ctrl u0 (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .texp_en   (texp_en),
        .div_hi    (div_hi),
        .div_lo    (div_lo),
        .spd_low   (spd_low),
        .lp_req    (lp_req),
        .wake_evt  (wake_evt),
        .tmr_exp   (tmr_exp),
        .core_clk  (core_clk),
        .mode_stat (mode_stat),
        .exp_wake  (exp_wake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: first rise after a push sets the reference, the next rise closes one period.
    always @(posedge core_clk) begin
        rise_cnt++;
        if (per_q.size() > 0) begin
            if (have_ref) begin
                chk(int'(($time - ref_t) / 20) == per_q[0], tag_q[0],
                    int'(($time - ref_t) / 20), per_q[0]);
                void'(per_q.pop_front());
                void'(tag_q.pop_front());
                have_ref = 1'b0;
            end else begin
                have_ref = 1'b1;
                ref_t    = $time;
            end
        end
    end

    // Driver: let the ratio settle, queue the expected period, wait for the monitor.
    task automatic expect_period(input int per, input string tag);
        repeat (3) @(posedge core_clk);
        @(negedge clk_in);
        per_q.push_back(per);
        tag_q.push_back(tag);
        while (per_q.size() != 0) @(negedge clk_in);
    endtask

    task automatic pulse_lp(input logic [1:0] code);
        @(negedge clk_in);
        mode_sel = code;
        lp_req   = 1'b1;
        @(negedge clk_in);
        lp_req   = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk_in);
        wake_evt = 1'b1;
        @(negedge clk_in);
        wake_evt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk_in);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        time tr;
        time tf;
        time t2;
        int  r0;
        // R2: reset state
        repeat (4) @(negedge clk_in);
        chk(mode_stat == 5'b00001, "R2", mode_stat, 1);
        chk(core_clk == 1'b0, "R2", core_clk, 0);
        chk(exp_wake == 1'b0, "R2", exp_wake, 0);
        rst_n = 1'b1;

        // R3: fast sub-mode periods
        expect_period(4, "R3");
        @(negedge clk_in) div_hi = 3'd3;
        expect_period(8, "R3");
        @(negedge clk_in) div_hi = 3'd0;
        expect_period(2, "R3");
        @(negedge clk_in) div_hi = 3'd3;
        expect_period(8, "R3");

        // R5: write during a high phase; old high phase kept, new low phase
        @(posedge core_clk);
        tr = $time;
        @(negedge clk_in) div_hi = 3'd1;
        @(negedge core_clk);
        tf = $time;
        chk(int'((tf - tr) / 20) == 4, "R5", int'((tf - tr) / 20), 4);
        @(posedge core_clk);
        t2 = $time;
        chk(int'((t2 - tf) / 20) == 1, "R5", int'((t2 - tf) / 20), 1);
        expect_period(2, "R5");

        // R6 and R4: slow sub-mode via a 0->1 on spd_low, back on 0
        @(negedge clk_in) div_lo = 3'd2;
        @(negedge clk_in) spd_low = 1'b1;
        expect_period(8, "R4");
        @(negedge clk_in) div_lo = 3'd0;
        expect_period(2, "R4");
        @(negedge clk_in) div_lo = 3'd2;
        expect_period(8, "R6");
        @(negedge clk_in) spd_low = 1'b0;
        expect_period(2, "R6");

        // R1/R7: doze keeps the slow clock running
        @(negedge clk_in) spd_low = 1'b1;
        expect_period(8, "R6");
        pulse_lp(2'b01);
        chk(mode_stat == 5'b00010, "R1", mode_stat, 2);
        expect_period(8, "R7");
        // R9: wake forces normal and fast even with spd_low held at 1
        pulse_wake();
        chk(mode_stat == 5'b00001, "R9", mode_stat, 1);
        expect_period(2, "R9");

        // R1: code 00 stays normal
        pulse_lp(2'b00);
        chk(mode_stat == 5'b00001, "R1", mode_stat, 1);

        // R7/R8: sleep parks the clock and ignores further strobes
        pulse_lp(2'b10);
        chk(mode_stat == 5'b00100, "R1", mode_stat, 4);
        repeat (10) @(negedge clk_in);
        r0 = rise_cnt;
        repeat (100) @(negedge clk_in);
        chk(rise_cnt == r0, "R7", rise_cnt - r0, 0);
        chk(core_clk == 1'b0, "R7", core_clk, 0);
        pulse_lp(2'b01);
        chk(mode_stat == 5'b00100, "R8", mode_stat, 4);
        // R10: disabled expiry neither raises exp_wake nor wakes
        @(negedge clk_in) tmr_exp = 1'b1;
        #1 chk(exp_wake == 1'b0, "R10", exp_wake, 0);
        @(negedge clk_in) tmr_exp = 1'b0;
        chk(mode_stat == 5'b00100, "R10", mode_stat, 4);
        pulse_wake();
        chk(mode_stat == 5'b00001, "R9", mode_stat, 1);

        // Deep-sleep with enabled expiry
        @(negedge clk_in) texp_en = 1'b1;
        pulse_lp(2'b11);
        chk(mode_stat == 5'b01000, "R1", mode_stat, 8);
        pulse_lp(2'b10);
        chk(mode_stat == 5'b01000, "R8", mode_stat, 8);
        @(negedge clk_in) tmr_exp = 1'b1;
        #1 chk(exp_wake == 1'b1, "R10", exp_wake, 1);
        @(negedge clk_in);
        chk(mode_stat == 5'b00001, "R9", mode_stat, 1);
        tmr_exp = 1'b0;
        #1 chk(exp_wake == 1'b1, "R11", exp_wake, 1);
        @(negedge clk_in);
        chk(exp_wake == 1'b0, "R11", exp_wake, 0);

        // Power-down: code 11 with expiry disabled
        @(negedge clk_in) texp_en = 1'b0;
        pulse_lp(2'b11);
        chk(mode_stat == 5'b10000, "R1", mode_stat, 16);
        @(negedge clk_in) tmr_exp = 1'b1;
        #1 chk(exp_wake == 1'b0, "R10", exp_wake, 0);
        @(negedge clk_in) tmr_exp = 1'b0;
        chk(mode_stat == 5'b10000, "R10", mode_stat, 16);
        pulse_wake();
        chk(mode_stat == 5'b00001, "R9", mode_stat, 1);
        expect_period(2, "R7");

        summary();
    end

endmodule